// File: doc/BRIEF.md
# Machine-Cycle Clock Divider Controller

This block derives a machine-cycle enable from the core clock. Software picks the rate by writing a 2-bit divide code. One machine cycle lasts 4, 64 or 1024 core clocks. The block guards how that code may change: the two slow rates can never be swapped directly, and every move between them must stop at divide-by-4 first. Writes that break this rule are dropped, and a sticky flag records them.

The block can also return to full speed on its own. Software sets a switchback enable. When it is set, the block forces the fastest rate at the start of an interrupt vector jump. A falling edge of a serial receive start bit does the same. That edge is held as pending and applied at the next instruction-boundary strobe. The currently effective code is always visible on an output, including any change made by hardware. A new rate only takes effect at the next machine-cycle boundary, so a cycle in progress is never cut short.

Top module: `mcyc_divider`

## Requirements
- R1: After reset the divide code reads 01, switchback is off and the illegal-write flag is 0. `cyc_en` is high in the first cycle after reset is released.
- R2: The codes are 01 (4 clocks), 10 (64 clocks) and 11 (1024 clocks). `cyc_en` is high for exactly one clock in every period of that many clocks.
- R3: A new code shows on `div_code` one clock after it is accepted. The machine cycle in progress finishes at its old length, and the next cycle uses the new length.
- R4: A write that would move directly between 10 and 11 is ignored as a whole, so neither the code nor the switchback enable changes. The illegal-write flag is set and stays set until reset.
- R5: A write of the reserved code 00 is ignored and sets the illegal-write flag.
- R6: With switchback on, a pulse on `irq_vector` makes `div_code` read 01 on the next clock. A force from hardware wins over a software write in the same cycle.
- R7: With switchback on, an `rx_start_fall` pulse is held pending. The code changes to 01 one clock after the next `insn_boundary` strobe that comes after the edge, and not before. An edge in the same cycle as a strobe waits for the following strobe.
- R8: With switchback off, interrupt and serial events leave the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_code | input | 2 | Requested divide code |
| wr_swb | input | 1 | Requested switchback enable |
| irq_vector | input | 1 | Start of the vector jump for a recognised enabled interrupt |
| rx_start_fall | input | 1 | Falling edge of the serial receive start bit |
| insn_boundary | input | 1 | Start of the next instruction |
| cyc_en | output | 1 | Machine-cycle enable pulse |
| div_code | output | 2 | Current effective divide code |
| illegal_wr | output | 1 | Sticky flag for rejected writes |

## Verification
The bench measures pulse periods at all three rates. It writes a new rate one clock into a machine cycle and checks that the cycle in progress keeps its old length. A design that reloads the counter at once would give a short cycle here. It tries direct slow-to-slow writes and reserved-code writes. A design that lets them through would show the forbidden code, or would turn switchback on from an illegal write. It also places a serial edge in the same cycle as a boundary strobe. A design that applies the switchback too early, or loses the pending edge, shows it in the code it reports.

// File: rtl/mcyc_divider.sv
module mcyc_divider #(
  parameter int FAST_LOG = 2,
  parameter int MID_LOG  = 6,
  parameter int SLOW_LOG = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_code,
  input  logic       wr_swb,
  input  logic       irq_vector,
  input  logic       rx_start_fall,
  input  logic       insn_boundary,
  output logic       cyc_en,
  output logic [1:0] div_code,
  output logic       illegal_wr
);
  localparam int CNT_W = SLOW_LOG;
  localparam logic [1:0] C4 = 2'b01, C64 = 2'b10, C1K = 2'b11;
  localparam logic [CNT_W-1:0] LIM4  = CNT_W'((1 << FAST_LOG) - 1);
  localparam logic [CNT_W-1:0] LIM64 = CNT_W'((1 << MID_LOG) - 1);
  localparam logic [CNT_W-1:0] LIM1K = CNT_W'((1 << SLOW_LOG) - 1);

  logic [1:0] code_q, run_q;
  logic swb_q, pend_q, bad_q;
  logic [CNT_W-1:0] cnt_q, lim;

  wire slow_hop = code_q[1] & wr_code[1] & (wr_code != code_q);
  wire wr_bad   = wr_en & ((wr_code == 2'b00) | slow_hop);
  wire wr_ok    = wr_en & ~wr_bad;
  wire force_sb = swb_q & (irq_vector | (pend_q & insn_boundary));

  always_comb begin
    case (run_q)
      C64:     lim = LIM64;
      C1K:     lim = LIM1K;
      default: lim = LIM4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= C4;
      run_q  <= C4;
      swb_q  <= 1'b0;
      pend_q <= 1'b0;
      bad_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (force_sb)   code_q <= C4;
      else if (wr_ok) code_q <= wr_code;
      if (wr_ok)  swb_q <= wr_swb;
      if (wr_bad) bad_q <= 1'b1;
      pend_q <= (pend_q & ~insn_boundary) | (rx_start_fall & swb_q);
      if (cnt_q == lim) begin
        cnt_q <= '0;
        run_q <= code_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cyc_en     = (cnt_q == '0);
  assign div_code   = code_q;
  assign illegal_wr = bad_q;

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en |=> !cyc_en);
  // R2
  no_reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_code != 2'b00);
  // R4
  no_slow_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_code[1] && $past(div_code[1])) |-> div_code == $past(div_code));
  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_wr |=> illegal_wr);
  // R5
  reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_code == 2'b00 && !irq_vector && !insn_boundary) |=> $stable(div_code));
  // R6
  irq_switchback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swb_q && irq_vector) |=> div_code == C4);
  // R8
  swb_off_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!swb_q && !wr_en) |=> $stable(div_code));
endmodule

// File: tb/tb_mcyc_divider.sv
module tb_mcyc_divider;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_swb = 0, irq_vector = 0, rx_start_fall = 0, insn_boundary = 0;
  logic [1:0] wr_code = 2'b01;
  logic cyc_en, illegal_wr;
  logic [1:0] div_code;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcyc_divider dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
    .wr_swb(wr_swb), .irq_vector(irq_vector), .rx_start_fall(rx_start_fall),
    .insn_boundary(insn_boundary), .cyc_en(cyc_en), .div_code(div_code),
    .illegal_wr(illegal_wr));

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] c, input logic s);
    wr_en = 1; wr_code = c; wr_swb = s;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic sync();
    while (!cyc_en) @(negedge clk);
  endtask

  task automatic period(output int p);
    sync();
    p = 0;
    do begin @(negedge clk); p++; end while (!cyc_en);
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  task automatic t_reset();
    int p;
    do_reset();
    check("R1 code", div_code, 1);
    check("R1 cyc_en", cyc_en, 1);
    check("R1 flag", illegal_wr, 0);
    pulse(irq_vector);
    check("R1 swb off", div_code, 1);
    period(p); check("R2 div4", p, 4);
  endtask

  task automatic t_rates();
    int p, t;
    sync(); wr(2'b10, 0); t = 1;
    check("R3 visible", div_code, 2);
    while (!cyc_en) begin @(negedge clk); t++; end
    check("R3 old length kept", t, 4);
    period(p); check("R2 div64", p, 64);
    sync(); wr(2'b01, 0); t = 1;
    while (!cyc_en) begin @(negedge clk); t++; end
    check("R3 slow cycle kept", t, 64);
    period(p); check("R2 back div4", p, 4);
    wr(2'b11, 0);
    period(p); period(p); check("R2 div1024", p, 1024);
  endtask

  task automatic t_illegal();
    do_reset();
    wr(2'b00, 0);
    check("R5 code", div_code, 1);
    check("R5 flag", illegal_wr, 1);
    do_reset();
    wr(2'b10, 0);
    check("R4 legal no flag", illegal_wr, 0);
    wr(2'b11, 1);
    check("R4 code", div_code, 2);
    check("R4 flag", illegal_wr, 1);
    pulse(irq_vector);
    check("R4 swb not taken", div_code, 2);
    wr(2'b01, 0);
    check("R4 sticky", illegal_wr, 1);
  endtask

  task automatic t_irq();
    wr(2'b01, 1); wr(2'b11, 1);
    check("R6 slow set", div_code, 3);
    pulse(irq_vector);
    check("R6 irq switchback", div_code, 1);
    wr(2'b10, 1);
    irq_vector = 1; wr(2'b10, 1); irq_vector = 0;
    check("R6 force beats write", div_code, 1);
  endtask

  task automatic t_rx();
    wr(2'b10, 1);
    pulse(rx_start_fall);
    repeat (3) @(negedge clk);
    check("R7 held pending", div_code, 2);
    pulse(insn_boundary);
    check("R7 applied at boundary", div_code, 1);
    wr(2'b10, 1);
    rx_start_fall = 1; insn_boundary = 1; @(negedge clk);
    rx_start_fall = 0; insn_boundary = 0;
    check("R7 same-cycle edge waits", div_code, 2);
    pulse(insn_boundary);
    check("R7 next boundary", div_code, 1);
  endtask

  task automatic t_swb_off();
    wr(2'b10, 0);
    pulse(irq_vector);
    check("R8 irq ignored", div_code, 2);
    pulse(rx_start_fall);
    pulse(insn_boundary);
    check("R8 rx ignored", div_code, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rates();
    t_illegal();
    t_irq();
    t_rx();
    t_swb_off();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule